// File: doc/BRIEF.md
# Power-Down Sequencer with Warm/Cold Start Flag

This block sequences the low-power states of a small 4-bit microcontroller core. It has two sleep modes. In the light mode the CPU clock stops, but the sub-clock oscillator, the wake timer and the display keep running. In the deep mode everything stops except RAM retention and the reset logic. Software enters either mode with a two-instruction sequence. First comes an arm instruction. The enter instruction for the chosen mode must follow it directly. An enter instruction that does not directly follow an arm retires as a no-operation.

The block leaves sleep on a wake event: the external wake line in either mode, or the wake-timer underflow in the light mode. On wake it raises a one-cycle restart request that sends the core to address zero, and it sets a sticky warm-start flag. A cold start comes from the reset pin, a watchdog reset or a supply-drop reset. It clears that flag. Software reads the flag with a skip-on-set query. It reads the timer flag with a skip-and-clear query, which tells a timer wake from an external wake.

The block also produces these outputs:
- the clock and domain enables for each mode;
- a stack-pointer preset on deep-mode entry;
- a one-cycle pulse that clears the interrupt and watchdog control bits on every entry;
- the override for the counter pin in the deep mode.

Top module: `pwrdn_ctrl`

## Requirements
- R1: An instruction flagged `op_enter_clk` that retires in the cycle right after an `op_arm` instruction moves `mode` from 0 (run) to 1 (light sleep) at the next clock edge. In mode 1, `cpu_clk_en` is 0 and `sub_clk_en`, `t3_run_en` and `lcd_en` are 1.
- R2: An `op_enter_ram` instruction that directly follows `op_arm` moves `mode` to 2 (deep sleep). In mode 2, `cpu_clk_en`, `sub_clk_en`, `t3_run_en` and `lcd_en` are all 0. `sp_load` is 1 for exactly the first cycle of mode 2, with `sp_load_val` = 7.
- R3: An enter instruction whose immediately preceding retired instruction was not `op_arm` leaves `mode` at 0. Idle cycles (`instr_valid` = 0) do not count as instructions.
- R4: In mode 1 or 2, `ext_wake` = 1 wakes the block. In mode 1, `t3_uflow` = 1 also wakes it; in mode 2, `t3_uflow` is ignored. A wake gives `mode` = 0, `p_flag` = 1 and `restart` = 1 one cycle later, and `restart` lasts one cycle.
- R5: `wdt_rst` or `vdrop_rst` gives `mode` = 0, `p_flag` = 0, `restart` = 1 and `t3f` = 0 one cycle later. This happens even when a wake or an enter instruction comes in the same cycle. The asynchronous `rst_n` = 0 gives `mode` = 0, `p_flag` = 0, `t3f` = 0 and all pulses at 0.
- R6: `t3f` is set one cycle after `t3_uflow` while `mode` is 0 or 1. It stays set across a wake and is cleared only by a cold start or by `op_query_t3`. A set in the same cycle as a clear wins.
- R7: A retired `op_query_p` gives `skip` = `p_flag` one cycle later. A retired `op_query_t3` gives `skip` = `t3f` one cycle later and clears `t3f`.
- R8: In mode 2, `cntr_ovr` = 1. `cntr_oe` is then 0 (pin released) when `cntr_sel` = 2'b11 and 1 (pin driven low) otherwise. Outside mode 2, `cntr_ovr` and `cntr_oe` are 0.
- R9: `ctl_clear` is 1 for exactly the first cycle of each sleep mode and is 0 at all other times.
- R10: While `mode` is not 0, instruction strobes have no effect. On wake the arm latch is clear, so an enter instruction as the first instruction after wake leaves `mode` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Reset pin, asynchronous, active low (cold) |
| instr_valid | input | 1 | An instruction retires this cycle |
| op_arm | input | 1 | Retiring instruction is the arm |
| op_enter_clk | input | 1 | Retiring instruction enters light sleep |
| op_enter_ram | input | 1 | Retiring instruction enters deep sleep |
| op_query_p | input | 1 | Retiring instruction tests the warm-start flag |
| op_query_t3 | input | 1 | Retiring instruction tests and clears the timer flag |
| ext_wake | input | 1 | External wake request |
| t3_uflow | input | 1 | Wake-timer underflow pulse |
| wdt_rst | input | 1 | Watchdog reset (cold, synchronous) |
| vdrop_rst | input | 1 | Supply-drop reset (cold, synchronous) |
| cntr_sel | input | 2 | Counter-pin function select; 2'b11 is input |
| mode | output | 2 | 0 run, 1 light sleep, 2 deep sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| sub_clk_en | output | 1 | Sub-clock oscillator enable |
| t3_run_en | output | 1 | Wake-timer enable |
| lcd_en | output | 1 | Display enable |
| p_flag | output | 1 | Warm-start flag |
| t3f | output | 1 | Timer-underflow flag |
| skip | output | 1 | Skip the next instruction |
| restart | output | 1 | Restart at address zero |
| sp_load | output | 1 | Load the stack pointer |
| sp_load_val | output | 3 | Stack-pointer preset value |
| ctl_clear | output | 1 | Clear interrupt and watchdog control bits |
| cntr_ovr | output | 1 | Counter pin overridden by sleep logic |
| cntr_oe | output | 1 | Counter pin drives low while overridden |

## Verification
The mode, the flags, `skip`, `restart`, `sp_load` and `ctl_clear` are all registered. Each is due exactly one clock edge after the cycle that holds its stimulus. The enables and the counter-pin outputs decode from the mode, so they change in that same cycle. The counter-pin outputs also follow `cntr_sel` at once. The bench drives its inputs at the falling edge and computes the next-state values from the same inputs just before the rising edge. It compares all outputs at the following falling edge, so every result is sampled one edge after its cause.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_CLKOP = 2'd1,
    PD_RAMBK = 2'd2
  } pd_mode_e;

  // CPU clock runs only when awake.
  function automatic logic pd_cpu_on(input pd_mode_e m);
    return (m == PD_RUN);
  endfunction

  // Sub-clock, wake timer and display stay up except in deep sleep.
  function automatic logic pd_aux_on(input pd_mode_e m);
    return (m != PD_RAMBK);
  endfunction

  // The wake timer can raise a wake only in light sleep.
  function automatic logic pd_timer_wakes(input pd_mode_e m);
    return (m == PD_CLKOP);
  endfunction

  // Counter-pin drive in deep sleep: released when set as an input.
  function automatic logic pd_cntr_drive(input pd_mode_e m,
                                         input logic [1:0] sel,
                                         input logic [1:0] in_sel);
    return (m == PD_RAMBK) && (sel != in_sel);
  endfunction

endpackage

// File: rtl/pd_arm_seq.sv
module pd_arm_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cold,
  input  logic run,
  input  logic instr_valid,
  input  logic op_arm,
  input  logic op_enter_clk,
  input  logic op_enter_ram,
  output logic armed,
  output logic enter_clk,
  output logic enter_ram
);
  logic retire;
  assign retire = instr_valid & run;

  // Latch holds only across the single next retired instruction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (cold)    armed <= 1'b0;
    else if (!run)    armed <= 1'b0;
    else if (retire)  armed <= op_arm;
  end

  assign enter_clk = retire & armed & op_enter_clk & ~cold;
  assign enter_ram = retire & armed & op_enter_ram & ~cold;

  // Input contract: at most one instruction strobe at a time.
  assert_ops_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> $onehot0({op_arm, op_enter_clk, op_enter_ram}));
endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm
  import pwrdn_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cold,
  input  logic     enter_clk,
  input  logic     enter_ram,
  input  logic     ext_wake,
  input  logic     t3_uflow,
  output pd_mode_e mode,
  output logic     p_flag,
  output logic     restart,
  output logic     ctl_clear,
  output logic     sp_load,
  output logic     wake_evt
);
  logic asleep;
  assign asleep   = (mode != PD_RUN);
  assign wake_evt = asleep & (ext_wake | (t3_uflow & pd_timer_wakes(mode)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= PD_RUN;
      p_flag    <= 1'b0;
      restart   <= 1'b0;
      ctl_clear <= 1'b0;
      sp_load   <= 1'b0;
    end else begin
      restart   <= cold | wake_evt;
      ctl_clear <= enter_clk | enter_ram;
      sp_load   <= enter_ram;
      if (cold) begin
        mode   <= PD_RUN;
        p_flag <= 1'b0;
      end else if (wake_evt) begin
        mode   <= PD_RUN;
        p_flag <= 1'b1;
      end else if (enter_clk) begin
        mode <= PD_CLKOP;
      end else if (enter_ram) begin
        mode <= PD_RAMBK;
      end
    end
  end

  assert_wake_sets_p_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !cold) |=> (p_flag && restart && mode == PD_RUN));

  assert_cold_clears_p_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> (!p_flag && restart && mode == PD_RUN));

  assert_clear_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> !ctl_clear);

  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !cold && !wake_evt) |=> !restart);
endmodule

// File: rtl/pd_flag_query.sv
module pd_flag_query
  import pwrdn_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cold,
  input  logic     retire,
  input  logic     op_query_p,
  input  logic     op_query_t3,
  input  logic     p_flag,
  input  logic     t3_uflow,
  input  pd_mode_e mode,
  output logic     t3f,
  output logic     skip
);
  logic t3_set, t3_clr;
  assign t3_set = t3_uflow & pd_aux_on(mode);
  assign t3_clr = retire & op_query_t3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t3f  <= 1'b0;
      skip <= 1'b0;
    end else if (cold) begin
      t3f  <= 1'b0;
      skip <= 1'b0;
    end else begin
      t3f  <= (t3f & ~t3_clr) | t3_set;
      skip <= retire & ((op_query_p & p_flag) | (op_query_t3 & t3f));
    end
  end

  assert_query_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> !(op_query_p && op_query_t3));

  assert_t3_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (t3f && !cold && !t3_clr) |=> t3f);
endmodule

// File: rtl/pd_out_map.sv
module pd_out_map
  import pwrdn_pkg::*;
#(
  parameter int          SEL_W       = 2,
  parameter logic [1:0]  CNTR_IN_SEL = 2'b11
) (
  input  pd_mode_e         mode,
  input  logic [SEL_W-1:0] cntr_sel,
  output logic             cpu_clk_en,
  output logic             sub_clk_en,
  output logic             t3_run_en,
  output logic             lcd_en,
  output logic             cntr_ovr,
  output logic             cntr_oe
);
  always_comb begin
    cpu_clk_en = pd_cpu_on(mode);
    sub_clk_en = pd_aux_on(mode);
    t3_run_en  = pd_aux_on(mode);
    lcd_en     = pd_aux_on(mode);
    cntr_ovr   = (mode == PD_RAMBK);
    cntr_oe    = pd_cntr_drive(mode, cntr_sel, CNTR_IN_SEL);
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int              SP_W        = 3,
  parameter logic [SP_W-1:0] SP_DEEP_VAL = 3'd7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic            op_arm,
  input  logic            op_enter_clk,
  input  logic            op_enter_ram,
  input  logic            op_query_p,
  input  logic            op_query_t3,
  input  logic            ext_wake,
  input  logic            t3_uflow,
  input  logic            wdt_rst,
  input  logic            vdrop_rst,
  input  logic [1:0]      cntr_sel,
  output logic [1:0]      mode,
  output logic            cpu_clk_en,
  output logic            sub_clk_en,
  output logic            t3_run_en,
  output logic            lcd_en,
  output logic            p_flag,
  output logic            t3f,
  output logic            skip,
  output logic            restart,
  output logic            sp_load,
  output logic [SP_W-1:0] sp_load_val,
  output logic            ctl_clear,
  output logic            cntr_ovr,
  output logic            cntr_oe
);
  pd_mode_e mode_q;
  logic cold, run, armed, enter_clk, enter_ram, wake_evt, retire;

  assign cold   = wdt_rst | vdrop_rst;
  assign run    = (mode_q == PD_RUN);
  assign retire = instr_valid & run;

  pd_arm_seq u_arm (
    .clk(clk), .rst_n(rst_n), .cold(cold), .run(run),
    .instr_valid(instr_valid), .op_arm(op_arm),
    .op_enter_clk(op_enter_clk), .op_enter_ram(op_enter_ram),
    .armed(armed), .enter_clk(enter_clk), .enter_ram(enter_ram)
  );

  pd_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cold(cold),
    .enter_clk(enter_clk), .enter_ram(enter_ram),
    .ext_wake(ext_wake), .t3_uflow(t3_uflow),
    .mode(mode_q), .p_flag(p_flag), .restart(restart),
    .ctl_clear(ctl_clear), .sp_load(sp_load), .wake_evt(wake_evt)
  );

  pd_flag_query u_flag (
    .clk(clk), .rst_n(rst_n), .cold(cold), .retire(retire),
    .op_query_p(op_query_p), .op_query_t3(op_query_t3),
    .p_flag(p_flag), .t3_uflow(t3_uflow), .mode(mode_q),
    .t3f(t3f), .skip(skip)
  );

  pd_out_map #(.SEL_W(2), .CNTR_IN_SEL(2'b11)) u_map (
    .mode(mode_q), .cntr_sel(cntr_sel),
    .cpu_clk_en(cpu_clk_en), .sub_clk_en(sub_clk_en),
    .t3_run_en(t3_run_en), .lcd_en(lcd_en),
    .cntr_ovr(cntr_ovr), .cntr_oe(cntr_oe)
  );

  assign mode        = mode_q;
  assign sp_load_val = SP_DEEP_VAL;

  // Any sleep entry was preceded by an armed latch.
  assert_entry_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PD_RUN && $past(mode_q) == PD_RUN) |-> $past(armed));

  assert_sp_on_deep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> (mode_q == PD_RAMBK && $past(mode_q) == PD_RUN));

  assert_asleep_no_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PD_RUN && $past(mode_q) != PD_RUN) |-> !skip);

  assert_wake_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> !run);
endmodule

// File: tb/tb_pwrdn_ctrl.sv
module tb_pwrdn_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid, op_arm, op_enter_clk, op_enter_ram, op_query_p, op_query_t3;
  logic ext_wake, t3_uflow, wdt_rst, vdrop_rst;
  logic [1:0] cntr_sel, mode;
  logic cpu_clk_en, sub_clk_en, t3_run_en, lcd_en, p_flag, t3f, skip, restart;
  logic sp_load, ctl_clear, cntr_ovr, cntr_oe;
  logic [2:0] sp_load_val;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  int m_mode, m_armed, m_p, m_t3f, m_skip, m_rst, m_clr, m_spl;

  always #10 clk = ~clk;

  pwrdn_ctrl dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_cpu(input int m); return (m == 0); endfunction
  function automatic int exp_aux(input int m); return (m != 2); endfunction
  function automatic int exp_oe(input int m, input int sel); return (m == 2 && sel != 3); endfunction

  task automatic compare_all();
    chk("R1", "mode", mode, m_mode);
    chk("R1", "cpu_clk_en", cpu_clk_en, exp_cpu(m_mode));
    chk("R2", "sub_clk_en", sub_clk_en, exp_aux(m_mode));
    chk("R2", "t3_run_en", t3_run_en, exp_aux(m_mode));
    chk("R2", "lcd_en", lcd_en, exp_aux(m_mode));
    chk("R2", "sp_load", sp_load, m_spl);
    chk("R2", "sp_load_val", sp_load_val, 7);
    chk("R4", "p_flag", p_flag, m_p);
    chk("R5", "restart", restart, m_rst);
    chk("R6", "t3f", t3f, m_t3f);
    chk("R7", "skip", skip, m_skip);
    chk("R8", "cntr_ovr", cntr_ovr, m_mode == 2);
    chk("R8", "cntr_oe", cntr_oe, exp_oe(m_mode, cntr_sel));
    chk("R9", "ctl_clear", ctl_clear, m_clr);
  endtask

  // op: 0 none, 1 arm, 2 enter light, 3 enter deep, 4 query P, 5 query timer
  task automatic step(input bit iv, input int op, input bit ew, input bit tu,
                      input bit wd, input bit vd, input int sel);
    int n_mode, n_armed, n_p, n_t3f, n_skip;
    bit run, cold, ret, ent_c, ent_r, wake;
    instr_valid = iv; op_arm = (op == 1); op_enter_clk = (op == 2);
    op_enter_ram = (op == 3); op_query_p = (op == 4); op_query_t3 = (op == 5);
    ext_wake = ew; t3_uflow = tu; wdt_rst = wd; vdrop_rst = vd; cntr_sel = 2'(sel);
    run = (m_mode == 0); cold = wd | vd; ret = iv & run;
    ent_c = ret && m_armed && op == 2 && !cold;
    ent_r = ret && m_armed && op == 3 && !cold;
    wake = !run && (ew || (tu && m_mode == 1));
    n_armed = (cold || !run) ? 0 : (ret ? (op == 1) : m_armed);
    n_mode = cold ? 0 : wake ? 0 : ent_c ? 1 : ent_r ? 2 : m_mode;
    n_p = cold ? 0 : wake ? 1 : m_p;
    n_t3f = cold ? 0 : ((m_t3f && !(ret && op == 5)) || (tu && m_mode != 2));
    n_skip = cold ? 0 : (ret && ((op == 4 && m_p) || (op == 5 && m_t3f)));
    @(posedge clk);
    m_rst = cold | wake; m_clr = ent_c | ent_r; m_spl = ent_r;
    m_mode = n_mode; m_armed = n_armed; m_p = n_p; m_t3f = n_t3f; m_skip = n_skip;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    instr_valid = 0; op_arm = 0; op_enter_clk = 0; op_enter_ram = 0;
    op_query_p = 0; op_query_t3 = 0; ext_wake = 0; t3_uflow = 0;
    wdt_rst = 0; vdrop_rst = 0; cntr_sel = 0;
    m_mode = 0; m_armed = 0; m_p = 0; m_t3f = 0; m_skip = 0; m_rst = 0; m_clr = 0; m_spl = 0;
    repeat (3) @(negedge clk);
    compare_all();                         // R5 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R3: enter without arm, and arm separated by another instruction
    step(1, 2, 0, 0, 0, 0, 0);
    chk("R3", "bare enter ignored", mode, 0);
    step(1, 1, 0, 0, 0, 0, 0); step(1, 4, 0, 0, 0, 0, 0); step(1, 3, 0, 0, 0, 0, 0);
    chk("R3", "gap after arm", mode, 0);
    // idle cycle between arm and enter keeps the arm (R1)
    step(1, 1, 0, 0, 0, 0, 0); idle(); step(1, 2, 0, 0, 0, 0, 0);
    chk("R1", "light entry", mode, 1);
    // R10: strobes ignored asleep, then timer wake (R4/R6)
    step(1, 1, 0, 0, 0, 0, 0); step(1, 3, 0, 0, 0, 0, 0);
    chk("R10", "asleep strobes", mode, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R4", "timer wake p", p_flag, 1);
    chk("R6", "t3f after timer wake", t3f, 1);
    step(1, 3, 0, 0, 0, 0, 0);
    chk("R10", "enter right after wake", mode, 0);
    step(1, 5, 0, 0, 0, 0, 0); idle();
    chk("R7", "t3 query skip", skip, 0);   // skip pulse was one cycle earlier
    // deep sleep, counter pin as input, timer ignored (R2/R4/R8)
    step(1, 1, 0, 0, 0, 0, 3); step(1, 3, 0, 0, 0, 0, 3);
    chk("R2", "deep entry", mode, 2);
    chk("R8", "input pin released", cntr_oe, 0);
    step(0, 0, 0, 1, 0, 0, 1);
    chk("R4", "timer ignored in deep", mode, 2);
    chk("R8", "pin driven low", cntr_oe, 1);
    // R5: cold and wake in the same cycle
    step(0, 0, 1, 0, 1, 0, 0);
    chk("R5", "cold beats wake", p_flag, 0);
    step(1, 4, 0, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      int op = ($urandom % 100 < 35) ? 1 : int'($urandom % 6);
      bit ew = ($urandom % 100) < 6;
      bit tu = ($urandom % 100) < 6;
      bit wd = (r == 0);
      bit vd = (r == 1);
      step(($urandom % 4) != 0, op, ew, tu, wd, vd, int'($urandom % 4));
    end

    // asynchronous reset pin mid-run (R5)
    step(1, 1, 0, 0, 0, 0, 0); step(1, 2, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_mode = 0; m_armed = 0; m_p = 0; m_t3f = 0; m_skip = 0; m_rst = 0; m_clr = 0; m_spl = 0;
    #1;
    chk("R5", "reset pin mode", mode, 0);
    @(negedge clk); rst_n = 1'b1;
    compare_all();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule